// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block tracks how error-prone a CAN node has recently been and decides how much the node may take part in bus traffic. It holds two error counters, one charged for trouble seen while receiving and one for trouble seen while transmitting. The frame sequencer moves each counter with increment and decrement commands. An increment carries either a unit step or a heavy step of eight. Error detection and the choice of step size stay in the sequencer.

From the two counters the unit derives a node state: error active, error passive or bus-off. Bus-off is sticky. While in bus-off, the unit ignores counter commands. It counts pulses from the sequencer, each pulse marking one completed run of eleven recessive bits. When the programmed number of such runs has been seen, both counters clear and the node is error active again. The state and both counts are registered outputs, and all of them change on the same clock edge as the command that moves them.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counts read 0 and the state output reads error active (code 2'b00).
- R2: An increment command adds 1, or 8 when its heavy-step flag is set. A decrement command subtracts 1. When increment and decrement are given in the same cycle, the increment wins. Each command takes effect on the next clock edge.
- R3: A decrement applied to a count of 0 leaves the count at 0.
- R4: The receive count saturates at 511 (all ones of its 9 bits) and never wraps.
- R5: The state is error passive (code 2'b01) when either count exceeds 127. It is error active when both counts are 127 or less and the node is not in bus-off.
- R6: The state becomes bus-off (code 2'b10) on the same edge on which the transmit count goes above 255. It stays bus-off whatever the counts do until recovery completes.
- R7: While in bus-off, all increment and decrement commands are ignored, and both counts hold their values.
- R8: In bus-off, the 128th recessive-run pulse clears both counts and returns the state to error active on that edge. After 127 pulses the node is still in bus-off.
- R9: Recessive-run pulses given outside bus-off have no effect on the counts or the state. They do not shorten a later recovery, so every bus-off needs all 128 pulses counted inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_inc | input | 1 | Increment the receive count |
| rx_heavy | input | 1 | Receive increment uses step 8 instead of 1 |
| rx_dec | input | 1 | Decrement the receive count |
| tx_inc | input | 1 | Increment the transmit count |
| tx_heavy | input | 1 | Transmit increment uses step 8 instead of 1 |
| tx_dec | input | 1 | Decrement the transmit count |
| idle_run | input | 1 | One-cycle pulse: a run of 11 recessive bits has completed |
| node_state | output | 2 | 00 error active, 01 error passive, 10 bus-off |
| rx_count | output | 9 | Receive error count |
| tx_count | output | 9 | Transmit error count |

## Verification
A wrong count shows up on the count outputs one clock after the command that caused it. A wrong threshold decision shows up on the state output on that same edge, because state and counts are registered together. A wrong bus-off flag appears in two ways: the state code changes, or the counts move or freeze when they should not. A recovery counter that is off by one stays hidden until the 127th or 128th run pulse, so the bench checks the state on both of those edges.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_t;
endpackage

// File: rtl/can_fc_err_counter.sv
module can_fc_err_counter #(
   parameter int W        = 9,
   parameter int BIG_STEP = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic         inc,
   input  logic         heavy,
   input  logic         dec,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_d
);
   localparam logic [W-1:0] MAXV  = {W{1'b1}};
   localparam logic [W:0]   BIG_V = (W+1)'(BIG_STEP);

   logic [W:0]   sum;
   logic [W-1:0] inc_val;

   assign sum = {1'b0, cnt_q} + (heavy ? BIG_V : (W+1)'(1));

   generate
      if (SATURATE) begin : g_sat
         assign inc_val = sum[W] ? MAXV : sum[W-1:0];
      end else begin : g_wrap
         assign inc_val = sum[W-1:0];
      end
   endgenerate

   always_comb begin
      if (clr)                         cnt_d = '0;
      else if (!en)                    cnt_d = cnt_q;
      else if (inc)                    cnt_d = inc_val;
      else if (dec && cnt_q != '0)     cnt_d = cnt_q - W'(1);
      else                             cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // R3: decrement at zero stays at zero
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !inc && dec && cnt_q == '0) |=> cnt_q == '0);

   // R2: unit step adds exactly one below the top
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && inc && !heavy && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + W'(1));

   generate
      if (SATURATE) begin : g_sat_chk
         // R4: saturated counter never wraps
         a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !clr && inc && cnt_q == MAXV) |=> cnt_q == MAXV);
      end
   endgenerate
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int RUNS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic idle_run,
   output logic done
);
   localparam int RW = $clog2(RUNS + 1);
   localparam logic [RW-1:0] LAST = RW'(RUNS - 1);

   logic [RW-1:0] runs_q;

   assign done = armed && idle_run && (runs_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                runs_q <= '0;
      else if (!armed || done)   runs_q <= '0;
      else if (idle_run)         runs_q <= runs_q + RW'(1);
   end

   // R8: run count stays below the target
   a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      runs_q <= LAST);

   // R9: nothing is counted outside bus-off
   a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> (runs_q == '0));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
   import can_fc_pkg::*;
#(
   parameter int CNT_W       = 9,
   parameter int BIG_STEP    = 8,
   parameter int PASSIVE_LIM = 127,
   parameter int BUSOFF_LIM  = 255,
   parameter int RECOV_RUNS  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_inc,
   input  logic             rx_heavy,
   input  logic             rx_dec,
   input  logic             tx_inc,
   input  logic             tx_heavy,
   input  logic             tx_dec,
   input  logic             idle_run,
   output logic [1:0]       node_state,
   output logic [CNT_W-1:0] rx_count,
   output logic [CNT_W-1:0] tx_count
);
   localparam logic [CNT_W-1:0] PAS_V = CNT_W'(PASSIVE_LIM);
   localparam logic [CNT_W-1:0] BO_V  = CNT_W'(BUSOFF_LIM);

   generate
      if (PASSIVE_LIM >= BUSOFF_LIM) begin : g_bad_lims
         $error("passive limit must lie below bus-off limit");
      end
      if ((1 << CNT_W) <= BUSOFF_LIM + BIG_STEP) begin : g_bad_width
         $error("counter width too small for bus-off limit plus heavy step");
      end
      if (BIG_STEP < 2 || RECOV_RUNS < 2) begin : g_bad_step
         $error("heavy step and recovery run count must be at least 2");
      end
   endgenerate

   logic             busoff_q, busoff_d, recov_done;
   logic [CNT_W-1:0] rx_d, tx_d;
   fc_state_t        state_q, state_d;

   can_fc_recovery #(.RUNS(RECOV_RUNS)) u_recov (
      .clk(clk), .rst_n(rst_n), .armed(busoff_q), .idle_run(idle_run), .done(recov_done)
   );

   can_fc_err_counter #(.W(CNT_W), .BIG_STEP(BIG_STEP), .SATURATE(1'b1)) u_rx_cnt (
      .clk(clk), .rst_n(rst_n), .en(!busoff_q), .clr(recov_done),
      .inc(rx_inc), .heavy(rx_heavy), .dec(rx_dec), .cnt_q(rx_count), .cnt_d(rx_d)
   );

   can_fc_err_counter #(.W(CNT_W), .BIG_STEP(BIG_STEP), .SATURATE(1'b0)) u_tx_cnt (
      .clk(clk), .rst_n(rst_n), .en(!busoff_q), .clr(recov_done),
      .inc(tx_inc), .heavy(tx_heavy), .dec(tx_dec), .cnt_q(tx_count), .cnt_d(tx_d)
   );

   always_comb begin
      if (recov_done)        busoff_d = 1'b0;
      else if (tx_d > BO_V)  busoff_d = 1'b1;
      else                   busoff_d = busoff_q;

      if (busoff_d)                        state_d = FC_BUSOFF;
      else if (rx_d > PAS_V || tx_d > PAS_V) state_d = FC_PASSIVE;
      else                                 state_d = FC_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busoff_q <= 1'b0;
         state_q  <= FC_ACTIVE;
      end else begin
         busoff_q <= busoff_d;
         state_q  <= state_d;
      end
   end

   assign node_state = state_q;

   // R6: a transmit count above the bus-off limit is only seen in bus-off
   a_r6_busoff_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count > BO_V) |-> node_state == FC_BUSOFF);

   // R6: bus-off is left only through a completed recovery
   a_r6_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (node_state == FC_BUSOFF && !recov_done) |=> node_state == FC_BUSOFF);

   // R7: counts frozen in bus-off
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (node_state == FC_BUSOFF && !idle_run) |=> ($stable(rx_count) && $stable(tx_count)));

   // R5: receive count above limit outside bus-off means passive
   a_r5_passive: assert property (@(posedge clk) disable iff (!rst_n)
      (node_state != FC_BUSOFF && rx_count > PAS_V) |-> node_state == FC_PASSIVE);

   // R8: recovery leaves zeroed counts
   a_r8_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
      recov_done |=> (rx_count == '0 && tx_count == '0 && node_state == FC_ACTIVE));

   // R5: no undefined state code
   a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      node_state != 2'b11);
endmodule

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_inc = 0, rx_heavy = 0, rx_dec = 0;
   logic       tx_inc = 0, tx_heavy = 0, tx_dec = 0, idle_run = 0;
   logic [1:0] node_state;
   logic [8:0] rx_count, tx_count;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   can_fault_confine u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_inc(rx_inc), .rx_heavy(rx_heavy), .rx_dec(rx_dec),
      .tx_inc(tx_inc), .tx_heavy(tx_heavy), .tx_dec(tx_dec),
      .idle_run(idle_run),
      .node_state(node_state), .rx_count(rx_count), .tx_count(tx_count)
   );

   // command bits: rx_inc rx_heavy rx_dec tx_inc tx_heavy tx_dec idle_run
   localparam logic [6:0] C_RX1  = 7'b1000000;
   localparam logic [6:0] C_RX8  = 7'b1100000;
   localparam logic [6:0] C_RXD  = 7'b0010000;
   localparam logic [6:0] C_TX1  = 7'b0001000;
   localparam logic [6:0] C_TX8  = 7'b0001100;
   localparam logic [6:0] C_TXD  = 7'b0000010;
   localparam logic [6:0] C_IDLE = 7'b0000001;
   localparam logic [6:0] C_NONE = 7'b0000000;

   // vector: command, expected rx, expected tx, expected state
   localparam logic [26:0] VEC [0:9] = '{
      {C_RX1,          9'd1,  9'd0, 2'b00},
      {C_RX8,          9'd9,  9'd0, 2'b00},
      {C_RXD,          9'd8,  9'd0, 2'b00},
      {C_TX8,          9'd8,  9'd8, 2'b00},
      {C_TX1 | C_TXD,  9'd8,  9'd9, 2'b00},
      {C_TXD,          9'd8,  9'd8, 2'b00},
      {C_RX8 | C_RXD,  9'd16, 9'd8, 2'b00},
      {C_IDLE,         9'd16, 9'd8, 2'b00},
      {C_NONE,         9'd16, 9'd8, 2'b00},
      {C_RXD | C_TXD,  9'd15, 9'd7, 2'b00}
   };

   task automatic cmd(input logic [6:0] c);
      {rx_inc, rx_heavy, rx_dec, tx_inc, tx_heavy, tx_dec, idle_run} = c;
      @(posedge clk);
      @(negedge clk);
      {rx_inc, rx_heavy, rx_dec, tx_inc, tx_heavy, tx_dec, idle_run} = '0;
   endtask

   task automatic chk(input logic [8:0] erx, input logic [8:0] etx,
                      input logic [1:0] est, input string tag);
      n_chk++;
      if (rx_count !== erx || tx_count !== etx || node_state !== est) begin
         n_bad++;
         $display("FAIL %s: got rx=%0d tx=%0d st=%b, expected rx=%0d tx=%0d st=%b",
                  tag, rx_count, tx_count, node_state, erx, etx, est);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      chk(9'd0, 9'd0, 2'b00, "R1 reset state");

      // R2 table walk
      for (int i = 0; i < 10; i++) begin
         cmd(VEC[i][26:20]);
         chk(VEC[i][19:11], VEC[i][10:2], VEC[i][1:0], $sformatf("R2 vector %0d", i));
      end

      // R3 decrement floor
      do_reset();
      cmd(C_RXD | C_TXD);
      chk(9'd0, 9'd0, 2'b00, "R3 decrement at zero");

      // R5 passive threshold on receive side
      for (int i = 0; i < 15; i++) cmd(C_RX8);
      for (int i = 0; i < 7; i++)  cmd(C_RX1);
      chk(9'd127, 9'd0, 2'b00, "R5 rx 127 still active");
      cmd(C_RX1);
      chk(9'd128, 9'd0, 2'b01, "R5 rx 128 passive");
      cmd(C_RXD);
      chk(9'd127, 9'd0, 2'b00, "R5 back to active");

      // R5 passive threshold on transmit side
      for (int i = 0; i < 16; i++) cmd(C_TX8);
      chk(9'd127, 9'd128, 2'b01, "R5 tx 128 passive");

      // R4 receive saturation
      for (int i = 0; i < 48; i++) cmd(C_RX8);
      chk(9'd511, 9'd128, 2'b01, "R4 rx saturates at 511");
      cmd(C_RX1);
      chk(9'd511, 9'd128, 2'b01, "R4 rx holds at 511");

      // R9 run pulses outside bus-off are ignored
      do_reset();
      for (int i = 0; i < 10; i++) cmd(C_IDLE);
      chk(9'd0, 9'd0, 2'b00, "R9 idle runs while active");

      // R6 bus-off entry exactly above 255
      for (int i = 0; i < 31; i++) cmd(C_TX8);
      for (int i = 0; i < 7; i++)  cmd(C_TX1);
      chk(9'd0, 9'd255, 2'b01, "R6 tx 255 not bus-off");
      cmd(C_TX1 | C_RX8);
      chk(9'd8, 9'd256, 2'b10, "R6 tx 256 enters bus-off");

      // R7 commands ignored in bus-off
      cmd(C_TXD | C_RXD);
      chk(9'd8, 9'd256, 2'b10, "R7 decrements ignored");
      cmd(C_RX8 | C_TX8);
      chk(9'd8, 9'd256, 2'b10, "R7 increments ignored");

      // R8 recovery count, R9 earlier pulses not credited
      for (int i = 0; i < 127; i++) cmd(C_IDLE);
      chk(9'd8, 9'd256, 2'b10, "R8 R9 127 runs still bus-off");
      cmd(C_IDLE);
      chk(9'd0, 9'd0, 2'b00, "R8 128th run recovers");

      // R6 entry with heavy step and a second full recovery
      for (int i = 0; i < 32; i++) cmd(C_TX8);
      chk(9'd0, 9'd256, 2'b10, "R6 heavy-step entry");
      for (int i = 0; i < 128; i++) cmd(C_IDLE);
      chk(9'd0, 9'd0, 2'b00, "R8 second recovery");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule